// File: doc/BRIEF.md
# CAN Transmit Queue with Staging Window

This block sits between a CPU register port and the frame-transmit engine of a CAN controller. Software never addresses queue slots directly. It fills one fixed staging window with an identifier, a length code and up to eight data bytes. It then writes the key value 0xFF to a commit register, which copies a snapshot of the window into the tail of a small circular queue.

The oldest committed frame is always presented to the transmit engine on a valid/done handshake. Each done pulse retires that frame, lowers the count of unsent frames and raises a sticky completion flag that drives the interrupt line. Software reads the unsent count from the control register. The difference between the frames it has committed and the frames still unsent tells it how many have gone out.

The staging window keeps its contents after a commit, so a frame can be sent again by a second commit alone. Clearing the enable bit empties the queue at once.

Top module: `can_txw_top`

## Requirements
- R1: After reset, tx_valid and irq are 0, the control register reads 0 and the staging registers read 0.
- R2: Register map on wr_addr/rd_addr:
  - 0 is the identifier, where bit 31 marks an extended frame and bit 30 a remote request.
  - 1 is the length code in bits 3:0.
  - 2 holds data bytes 0..3 in bits 7:0 upward, and 3 holds bytes 4..7.
  - 4 is control: bit 0 enables the queue, bits 3:1 are the unsent count (read only), and the other bits read 0.
  - 5 is the commit register.
  - 6 is status, where bit 3 is the completion flag.
  - A read started with rd_en returns its data on rd_data one cycle later.
- R3: A write of 0xFF in bits 7:0 to address 5, while enabled and with fewer than DEPTH frames unsent, appends the staged frame and increments the unsent count. Any other value written there is ignored.
- R4: A commit while DEPTH frames are unsent is ignored, and the count stays at DEPTH.
- R5: A frame whose identifier has bit 30 set is presented with tx_data equal to 0, whatever the staged data bytes are.
- R6: tx_valid is high whenever the count is nonzero. The head fields show the oldest unsent frame. A tx_done pulse pops the head in commit order and decrements the count. A tx_done while nothing is unsent has no effect.
- R7: A commit and a pop in the same cycle leave the count unchanged, and both are carried out.
- R8: Each pop sets the completion flag, and irq follows it. A write to address 6 with bit 3 at 0 clears the flag, and a write with bit 3 at 1 leaves it. A pop in the same cycle as a clear leaves the flag set.
- R9: Writing control with bit 0 at 0 discards all unsent frames, so the count reads 0 and tx_valid drops. A commit while disabled is ignored.
- R10: The staging registers keep their values across commits, and a repeated commit sends the same frame again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| tx_valid | output | 1 | Head frame available |
| tx_id | output | 32 | Head identifier word |
| tx_dlc | output | 4 | Head length code |
| tx_data | output | 64 | Head data bytes, byte 0 in bits 7:0 |
| tx_done | input | 1 | Transmit engine finished the head frame |
| irq | output | 1 | Completion flag |

## Verification
The bench builds the block at its default depth of four. At that depth the three-bit count field covers every value from empty to full, and five commits reach both the full-queue rejection and the wrap of the circular pointers. The random phase mixes staging writes, valid and invalid commit keys, done pulses, simultaneous commit and pop, flag clears and disables. These make the collisions of pop with clear, of pop with commit, and of flush with pending frames occur many times. A bench model of the queue predicts the head frame and the flag after every step.

// File: rtl/can_txw_pkg.sv
package can_txw_pkg;
  localparam int ADDR_W     = 3;
  localparam int DATA_W     = 32;
  localparam int ID_W       = 32;
  localparam int DLC_W      = 4;
  localparam int PAY_W      = 64;
  localparam int REMOTE_BIT = 30;
  localparam int EN_BIT     = 0;
  localparam int FLAG_BIT   = 3;
  localparam int CNT_LSB    = 1;
  localparam logic [7:0] COMMIT_KEY = 8'hFF;

  typedef enum logic [ADDR_W-1:0] {
    RA_ID   = 3'd0,
    RA_DLC  = 3'd1,
    RA_DLO  = 3'd2,
    RA_DHI  = 3'd3,
    RA_CTRL = 3'd4,
    RA_PTR  = 3'd5,
    RA_STAT = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic [DLC_W-1:0] dlc;
    logic [PAY_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/can_txw_stage.sv
module can_txw_stage
  import can_txw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output frame_t            staged
);
  localparam int HALF = PAY_W / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      staged <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        RA_ID:   staged.id             <= wr_data[ID_W-1:0];
        RA_DLC:  staged.dlc            <= wr_data[DLC_W-1:0];
        RA_DLO:  staged.data[HALF-1:0] <= wr_data[HALF-1:0];
        RA_DHI:  staged.data[PAY_W-1:HALF] <= wr_data[HALF-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/can_txw_queue.sv
module can_txw_queue
  import can_txw_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  frame_t        din,
  output frame_t        dout,
  output logic [CW-1:0] count
);
  frame_t        mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ok = push && (count < CW'(DEPTH)) && !flush;
  assign pop_ok  = pop && (count != '0);

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  assign dout = mem[rp];
endmodule

// File: rtl/can_txw_flag.sv
module can_txw_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/can_txw_top.sv
module can_txw_top
  import can_txw_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              tx_valid,
  output logic [ID_W-1:0]   tx_id,
  output logic [DLC_W-1:0]  tx_dlc,
  output logic [PAY_W-1:0]  tx_data,
  input  logic              tx_done,
  output logic              irq
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int HALF = PAY_W / 2;

  frame_t        staged, snap, head;
  logic          en_q, commit_w, flush_w, clr_w, pop_set;
  logic [CW-1:0] unsent;

  can_txw_stage u_stage (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .staged(staged)
  );

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else if (wr_en && wr_addr == RA_CTRL) en_q <= wr_data[EN_BIT];
  end

  assign commit_w = wr_en && (wr_addr == RA_PTR) && (wr_data[7:0] == COMMIT_KEY) && en_q;
  assign flush_w  = wr_en && (wr_addr == RA_CTRL) && !wr_data[EN_BIT];
  assign clr_w    = wr_en && (wr_addr == RA_STAT) && !wr_data[FLAG_BIT];
  assign pop_set  = tx_done && (unsent != '0);

  always_comb begin
    snap = staged;
    if (staged.id[REMOTE_BIT]) snap.data = '0;
  end

  can_txw_queue #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst(rst), .push(commit_w), .pop(tx_done),
    .flush(flush_w), .din(snap), .dout(head), .count(unsent)
  );

  can_txw_flag u_flag (
    .clk(clk), .rst(rst), .set(pop_set), .clr(clr_w), .flag(irq)
  );

  assign tx_valid = (unsent != '0);
  assign tx_id    = head.id;
  assign tx_dlc   = head.dlc;
  assign tx_data  = head.data;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        RA_ID:   rd_data <= staged.id;
        RA_DLC:  rd_data <= DATA_W'(staged.dlc);
        RA_DLO:  rd_data <= DATA_W'(staged.data[HALF-1:0]);
        RA_DHI:  rd_data <= DATA_W'(staged.data[PAY_W-1:HALF]);
        RA_CTRL: rd_data <= (DATA_W'(unsent) << CNT_LSB) | DATA_W'(en_q);
        RA_STAT: rd_data <= DATA_W'(irq) << FLAG_BIT;
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/can_txw_chk.sv
module can_txw_chk #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          en_q,
  input logic [CW-1:0] unsent,
  input logic          commit_w,
  input logic          tx_done,
  input logic          tx_valid,
  input logic [31:0]   tx_id,
  input logic [63:0]   tx_data,
  input logic          irq
);
  // R3 count never exceeds the depth
  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    unsent <= CW'(DEPTH));

  // R4 full queue rejects a commit
  a_r4_full_hold: assert property (@(posedge clk) disable iff (rst)
    (commit_w && unsent == CW'(DEPTH) && !tx_done && en_q) |=> unsent == CW'(DEPTH));

  // R5 remote frame carries no data
  a_r5_remote_zero: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_id[30]) |-> tx_data == '0);

  // R6 pop decrements
  a_r6_pop_dec: assert property (@(posedge clk) disable iff (rst)
    (tx_done && tx_valid && !commit_w && en_q) |=> unsent == $past(unsent) - 1'b1);

  // R8 completion raises the flag
  a_r8_flag_set: assert property (@(posedge clk) disable iff (rst)
    (tx_done && tx_valid) |=> irq);

  // R9 disabled queue is empty
  a_r9_flush_empty: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> (unsent == '0 && !tx_valid));
endmodule

bind can_txw_top can_txw_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .en_q(en_q), .unsent(unsent), .commit_w(commit_w),
  .tx_done(tx_done), .tx_valid(tx_valid), .tx_id(tx_id), .tx_data(tx_data),
  .irq(irq)
);

// File: tb/can_txw_top_test.sv
module can_txw_top_test;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        tx_valid;
  logic [31:0] tx_id;
  logic [3:0]  tx_dlc;
  logic [63:0] tx_data;
  logic        tx_done = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [31:0] s_id;
  logic [3:0]  s_dlc;
  logic [31:0] s_lo, s_hi;
  logic [31:0] q_id  [DEPTH];
  logic [3:0]  q_dlc [DEPTH];
  logic [63:0] q_dat [DEPTH];
  int          m_head, m_cnt;
  logic        m_en, m_irq;

  always #10 clk = ~clk;

  can_txw_top #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .tx_valid(tx_valid),
    .tx_id(tx_id), .tx_dlc(tx_dlc), .tx_data(tx_data), .tx_done(tx_done),
    .irq(irq)
  );

  function automatic logic [63:0] exp_payload(input logic [31:0] id,
                                              input logic [31:0] lo,
                                              input logic [31:0] hi);
    return id[30] ? 64'd0 : {hi, lo};
  endfunction

  function automatic logic [31:0] exp_ctrl(input int cnt, input logic en);
    return (32'(cnt) << 1) | 32'(en);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    s_id = '0; s_dlc = '0; s_lo = '0; s_hi = '0;
    m_head = 0; m_cnt = 0; m_en = 1'b0; m_irq = 1'b0;
  endtask

  // one clock with an optional write and an optional done pulse
  task automatic step(input logic w, input logic [2:0] a, input logic [31:0] d,
                      input logic done);
    logic set, push, flush;
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; tx_done = done;
    @(posedge clk);
    set   = done && (m_cnt > 0);
    push  = w && a == 3'd5 && d[7:0] == 8'hFF && m_en && m_cnt < DEPTH;
    flush = w && a == 3'd4 && !d[0];
    if (w) begin
      case (a)
        3'd0: s_id  = d;
        3'd1: s_dlc = d[3:0];
        3'd2: s_lo  = d;
        3'd3: s_hi  = d;
        3'd4: m_en  = d[0];
        default: ;
      endcase
    end
    if (set) m_irq = 1'b1;
    else if (w && a == 3'd6 && !d[3]) m_irq = 1'b0;
    if (flush) begin
      m_cnt = 0; m_head = 0;
    end else begin
      if (push) begin
        q_id [(m_head + m_cnt) % DEPTH] = s_id;
        q_dlc[(m_head + m_cnt) % DEPTH] = s_dlc;
        q_dat[(m_head + m_cnt) % DEPTH] = exp_payload(s_id, s_lo, s_hi);
      end
      if (set) begin
        m_head = (m_head + 1) % DEPTH; m_cnt--;
      end
      if (push) m_cnt++;
    end
    @(negedge clk);
    wr_en = 1'b0; tx_done = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic compare(input string req);
    logic [31:0] c;
    chk(req, 64'(tx_valid), 64'(m_cnt != 0));
    chk({req, " R8 irq"}, 64'(irq), 64'(m_irq));
    if (m_cnt != 0) begin
      chk({req, " R6 head id"}, 64'(tx_id), 64'(q_id[m_head]));
      chk({req, " R6 head dlc"}, 64'(tx_dlc), 64'(q_dlc[m_head]));
      chk({req, " R5 head data"}, tx_data, q_dat[m_head]);
    end
    rd(3'd4, c);
    chk({req, " R2 ctrl"}, 64'(c), 64'(exp_ctrl(m_cnt, m_en)));
  endtask

  task automatic stage(input logic [31:0] id, input logic [3:0] dlc,
                       input logic [31:0] lo, input logic [31:0] hi);
    step(1, 3'd0, id, 0);
    step(1, 3'd1, 32'(dlc), 0);
    step(1, 3'd2, lo, 0);
    step(1, 3'd3, hi, 0);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    model_reset();
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    compare("R1 reset");
    rd(3'd0, v); chk("R1 staged id", 64'(v), 64'd0);
    rd(3'd6, v); chk("R1 status", 64'(v), 64'd0);

    // R9 commit while disabled ignored
    stage(32'h0000_0123, 4'd8, 32'h4433_2211, 32'h8877_6655);
    step(1, 3'd5, 32'hFF, 0);
    compare("R9 disabled commit");

    // R3 enable and commit
    step(1, 3'd4, 32'h1, 0);
    step(1, 3'd5, 32'hFF, 0);
    compare("R3 first commit");
    chk("R3 data", tx_data, 64'h8877_6655_4433_2211);

    // R3 wrong key ignored
    step(1, 3'd5, 32'h7F, 0);
    compare("R3 bad key");

    // R5 remote frame, then fill to R4
    stage(32'h4000_0055, 4'd2, 32'hDEAD_BEEF, 32'hCAFE_F00D);
    step(1, 3'd5, 32'hFF, 0);
    step(1, 3'd5, 32'hFF, 0);
    step(1, 3'd5, 32'hFF, 0);
    compare("R4 full");
    step(1, 3'd5, 32'hFF, 0);
    compare("R4 commit at full");
    rd(3'd4, v); chk("R4 ctrl full", 64'(v), 64'h9);

    // R6 pop in order, R5 remote head
    step(0, 3'd0, 0, 1);
    compare("R6 pop");
    chk("R5 remote data", tx_data, 64'd0);
    chk("R8 irq set", 64'(irq), 64'd1);

    // R8 clear semantics
    step(1, 3'd6, 32'h8, 0);
    compare("R8 keep");
    step(1, 3'd6, 32'h0, 1);
    compare("R8 set wins");
    step(1, 3'd6, 32'h0, 0);
    compare("R8 clear");

    // R7 commit with pop
    step(1, 3'd5, 32'hFF, 1);
    compare("R7 simultaneous");

    // R10 staging kept
    rd(3'd0, v); chk("R10 staged id", 64'(v), 64'h4000_0055);
    rd(3'd1, v); chk("R10 staged dlc", 64'(v), 64'd2);

    // R9 flush, then R6 done on empty ignored
    step(1, 3'd6, 32'h0, 0);
    step(1, 3'd4, 32'h0, 0);
    compare("R9 flush");
    step(0, 3'd0, 0, 1);
    compare("R6 done on empty");
    step(1, 3'd4, 32'h1, 0);

    // random phase
    for (int i = 0; i < 600; i++) begin
      int op = int'($urandom % 10);
      case (op)
        0, 1, 2, 3: step(1, 3'($urandom % 4), $urandom, 0);
        4, 5:       step(1, 3'd5, ($urandom % 4 != 0) ? 32'hFF : ($urandom & 32'hFE), 0);
        6:          step(0, 3'd0, 0, 1);
        7:          step(1, 3'd5, 32'hFF, 1);
        8:          step(1, 3'd6, $urandom, $urandom % 2 == 1);
        default:    step(1, 3'd4, ($urandom % 6 != 0) ? 32'h1 : 32'h0, 0);
      endcase
      compare("R6 random");
    end
    summary();
  end
endmodule